// File: doc/BRIEF.md
# Sub-Word Register Access Port

This block sits between a byte-addressed register bus and a small bank of 32-bit registers. It carries byte, halfword and word reads and writes. For an access narrower than a word it picks the byte lanes from the two low address bits. A write merges the right-aligned write data into those lanes only, and every other bit of the register keeps its value. A read returns the selected lanes shifted down to bit 0, with all bits above them zero.

Any access the block cannot carry gets an error response in the same cycle as the strobe, and it changes no register. This covers a halfword on an odd address, a word that is not word aligned, or a size code outside the three it knows. Registers flagged by a parameter mask are read-only. They take writes without complaint and without effect.

Every strobe is accepted in the cycle it is presented. There is no back-pressure and no wait state, so the bus side may issue one access per clock without gaps. Read data and the error flag are combinational responses to the strobe cycle. Write data lands at the next rising edge.

Top module: `subword_reg_port`

## Requirements
- R1: After reset, register i (word address 4*i) reads RST_SEED XOR (i * 0x11111111), and rsp_err is low.
- R2: A byte access (acc_size = 1) is legal at any address. It uses the lane that starts at bit acc_addr[1:0]*8. A byte write replaces only those 8 bits of the register and keeps the other 24 bits.
- R3: A halfword access (acc_size = 2) at an even address uses bits acc_addr[1]*16 and upward. A halfword write replaces only those 16 bits.
- R4: A halfword access with acc_addr[0] = 1 raises rsp_err in the strobe cycle and leaves every register unchanged.
- R5: A word access (acc_size = 4) with acc_addr[1:0] not zero raises rsp_err in the strobe cycle and leaves every register unchanged.
- R6: Any acc_size value other than 1, 2 or 4 raises rsp_err in the strobe cycle and writes nothing.
- R7: A legal byte or halfword read returns the selected lanes on rsp_rdata starting at bit 0, with all higher bits zero.
- R8: An aligned word write replaces all 32 bits, and an aligned word read returns the whole register.
- R9: A write to a register whose bit is set in RO_MASK (by default only register 3) leaves it unchanged and does not raise rsp_err.
- R10: With acc_stb low, rsp_err is low, rsp_rdata is zero and no register changes, whatever the other inputs are. rsp_rdata is also zero during a write and during an errored access.
- R11: Accesses may follow one per clock with no gap. A read in the cycle right after a write sees the merged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | Access strobe, one access per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address. Bits [ADDR_W-1:2] select the register and [1:0] select the lane |
| acc_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| acc_wdata | input | 32 | Write data, right-aligned |
| rsp_rdata | output | 32 | Read data, right-aligned, valid in the strobe cycle |
| rsp_err | output | 1 | Error response, asserted in the strobe cycle |

## Verification
The error check and the write commit act in the same cycle. A misaligned or badly sized write must be refused at the very edge on which a legal write with the same data would have landed. The bench provokes this with back-to-back streams that mix legal and illegal writes to the same register, including odd-address halfwords and off-by-one words. Each outcome is judged by reading the register in the very next cycle. A behavioural byte-array model predicts both the error flag of the strobe cycle and the value that follows.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int SZ_W   = 3;

  localparam logic [SZ_W-1:0] SZ_BYTE = 3'd1;
  localparam logic [SZ_W-1:0] SZ_HALF = 3'd2;
  localparam logic [SZ_W-1:0] SZ_WORD = 3'd4;

  // Reset pattern of register i: seed folded with a per-index stripe.
  function automatic logic [DATA_W-1:0] rst_value(input logic [DATA_W-1:0] seed,
                                                   input int unsigned idx);
    return seed ^ (DATA_W'(idx) * 32'h1111_1111);
  endfunction
endpackage

// File: rtl/srp_decode.sv
module srp_decode
  import srp_pkg::*;
(
  input  logic [SZ_W-1:0]   size,
  input  logic [1:0]        lo,
  output logic              ok,
  output logic [LANES-1:0]  be,
  output logic [4:0]        shift,
  output logic [DATA_W-1:0] rd_mask
);
  always_comb begin
    ok      = 1'b0;
    be      = '0;
    rd_mask = '0;
    case (size)
      SZ_BYTE: begin
        ok      = 1'b1;
        be      = LANES'(4'b0001 << lo);
        rd_mask = 32'h0000_00FF;
      end
      SZ_HALF: begin
        ok      = ~lo[0];
        be      = ok ? LANES'(4'b0011 << lo) : '0;
        rd_mask = 32'h0000_FFFF;
      end
      SZ_WORD: begin
        ok      = (lo == 2'b00);
        be      = ok ? '1 : '0;
        rd_mask = '1;
      end
      default: ;
    endcase
  end

  assign shift = {lo, 3'b000};
endmodule

// File: rtl/srp_bank.sv
module srp_bank
  import srp_pkg::*;
#(
  parameter int          NREGS    = 4,
  parameter logic [63:0] RO_MASK  = 64'h8,
  parameter logic [31:0] RST_SEED = 32'hA5C3_0F96,
  localparam int         IDX_W    = $clog2(NREGS)
)(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [LANES-1:0]              wr_be,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NREGS-1:0][DATA_W-1:0]  q
);
  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    localparam logic [DATA_W-1:0] RV = rst_value(RST_SEED, r);
    if (RO_MASK[r]) begin : g_ro
      assign q[r] = RV;
    end else begin : g_rw
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(r));
      for (genvar b = 0; b < LANES; b++) begin : g_lane
        always_ff @(posedge clk) begin
          if (!rst_n)
            q[r][b*8 +: 8] <= RV[b*8 +: 8];
          else if (hit && wr_be[b])
            q[r][b*8 +: 8] <= wr_data[b*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/srp_rdalign.sv
module srp_rdalign
  import srp_pkg::*;
(
  input  logic              en,
  input  logic [DATA_W-1:0] word,
  input  logic [4:0]        shift,
  input  logic [DATA_W-1:0] rd_mask,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (en) rdata = (word >> shift) & rd_mask;
  end
endmodule

// File: rtl/subword_reg_port.sv
module subword_reg_port
  import srp_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter logic [63:0] RO_MASK  = 64'h8,
  parameter logic [31:0] RST_SEED = 32'hA5C3_0F96
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_stb,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int NREGS = 1 << IDX_W;

  logic                         ok;
  logic [LANES-1:0]             be;
  logic [4:0]                   shift;
  logic [DATA_W-1:0]            rd_mask;
  logic [IDX_W-1:0]             idx;
  logic                         wr_en;
  logic [DATA_W-1:0]            wr_data;
  logic [NREGS-1:0][DATA_W-1:0] bank_q;

  assign idx = acc_addr[ADDR_W-1:2];

  srp_decode u_dec (
    .size(acc_size), .lo(acc_addr[1:0]),
    .ok(ok), .be(be), .shift(shift), .rd_mask(rd_mask)
  );

  // Error only when a strobe carries an access that cannot be served.
  assign rsp_err = acc_stb & ~ok;
  assign wr_en   = acc_stb & acc_we & ok & ~RO_MASK[idx];
  assign wr_data = acc_wdata << shift;

  srp_bank #(.NREGS(NREGS), .RO_MASK(RO_MASK), .RST_SEED(RST_SEED)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx),
    .wr_be(be), .wr_data(wr_data), .q(bank_q)
  );

  srp_rdalign u_rd (
    .en(acc_stb & ~acc_we & ok), .word(bank_q[idx]),
    .shift(shift), .rd_mask(rd_mask), .rdata(rsp_rdata)
  );

  // Checker state: bits outside the written lanes, captured at the write.
  logic              chk_arm;
  logic [IDX_W-1:0]  chk_idx;
  logic [DATA_W-1:0] chk_keep_mask, chk_keep_val, lane_bits;

  always_comb
    for (int b = 0; b < LANES; b++) lane_bits[b*8 +: 8] = {8{be[b]}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_arm       <= 1'b0;
      chk_idx       <= '0;
      chk_keep_mask <= '0;
      chk_keep_val  <= '0;
    end else begin
      chk_arm       <= wr_en;
      chk_idx       <= idx;
      chk_keep_mask <= ~lane_bits;
      chk_keep_val  <= bank_q[idx] & ~lane_bits;
    end
  end

  // R2
  lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_arm |-> ((bank_q[chk_idx] & chk_keep_mask) == chk_keep_val));
  // R4
  half_misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_size == SZ_HALF && acc_addr[0]) |-> rsp_err);
  // R5
  word_misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_size == SZ_WORD && acc_addr[1:0] != 2'b00) |-> rsp_err);
  // R6
  bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_size != SZ_BYTE && acc_size != SZ_HALF && acc_size != SZ_WORD) |-> rsp_err);
  // R4
  err_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> $stable(bank_q));
  // R9
  ro_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_we && RO_MASK[idx]) |=> $stable(bank_q));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_stb |-> (!rsp_err && rsp_rdata == '0));
  // R7
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !acc_we && acc_size == SZ_BYTE) |-> (rsp_rdata[31:8] == '0));
endmodule

// File: tb/subword_reg_port_tb.sv
`timescale 1ns/1ps
module subword_reg_port_tb_top;
  localparam int          ADDR_W   = 4;
  localparam int          NREGS    = 4;
  localparam logic [31:0] SEED     = 32'hA5C3_0F96;
  localparam logic [63:0] ROM      = 64'h8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_stb = 1'b0, acc_we = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [2:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [31:0] mdl [NREGS];

  always #2.5 clk = ~clk;

  subword_reg_port #(.ADDR_W(ADDR_W), .RO_MASK(ROM), .RST_SEED(SEED)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

  function automatic int nbytes_ok(input logic [2:0] sz, input logic [3:0] a);
    if (sz == 3'd1) return 1;
    if (sz == 3'd2) return (a % 2 == 0) ? 2 : 0;
    if (sz == 3'd4) return (a % 4 == 0) ? 4 : 0;
    return 0;
  endfunction

  // One access cycle: drive at the falling edge, judge 1 ns later, then
  // advance the model at the rising edge.
  task automatic cyc(input bit stb, input bit we, input logic [3:0] a,
                     input logic [2:0] sz, input logic [31:0] wd, input string req);
    int n, reg_i, lane;
    logic        e_err;
    logic [31:0] e_rd;
    @(negedge clk);
    acc_stb = stb; acc_we = we; acc_addr = a; acc_size = sz; acc_wdata = wd;
    #1;
    n = nbytes_ok(sz, a);
    reg_i = int'(a) / 4;
    lane = int'(a) % 4;
    e_err = stb && (n == 0);
    e_rd = '0;
    if (stb && !we && n > 0)
      for (int k = 0; k < n; k++) e_rd[k*8 +: 8] = mdl[reg_i][(lane+k)*8 +: 8];
    compared++;
    if (rsp_err !== e_err || rsp_rdata !== e_rd) begin
      mismatched++;
      $display("FAIL %s: addr=%0d size=%0d we=%0d actual err=%0b rdata=%08h expected err=%0b rdata=%08h",
               req, a, sz, we, rsp_err, rsp_rdata, e_err, e_rd);
    end
    @(posedge clk);
    if (stb && we && n > 0 && !ROM[reg_i])
      for (int k = 0; k < n; k++) mdl[reg_i][(lane+k)*8 +: 8] = wd[k*8 +: 8];
  endtask

  task automatic rd_word(input int r, input string req);
    cyc(1, 0, 4'(r*4), 3'd4, 32'h0, req);
  endtask

  initial begin
    for (int i = 0; i < NREGS; i++) mdl[i] = SEED ^ (32'(i) * 32'h1111_1111);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset values and quiet error line
    for (int i = 0; i < NREGS; i++) rd_word(i, "R1");
    cyc(0, 0, 4'd0, 3'd4, 32'h0, "R1");

    // R8 full word write and read
    cyc(1, 1, 4'd0, 3'd4, 32'h1234_5678, "R8");
    rd_word(0, "R8");

    // R2 byte writes at every lane of register 1
    cyc(1, 1, 4'd6, 3'd1, 32'hFFFF_FFEE, "R2");
    rd_word(1, "R2");
    for (int a = 4; a < 8; a++) cyc(1, 1, 4'(a), 3'd1, 32'(8'h30 + a), "R2");
    rd_word(1, "R2");
    for (int a = 4; a < 8; a++) cyc(1, 0, 4'(a), 3'd1, 32'h0, "R2");

    // R3 halfword writes at both halves of register 2
    cyc(1, 1, 4'd10, 3'd2, 32'h0000_BEEF, "R3");
    rd_word(2, "R3");
    cyc(1, 1, 4'd8, 3'd2, 32'hAAAA_CAFE, "R3");
    rd_word(2, "R3");

    // R4 odd halfword refused, register untouched
    cyc(1, 1, 4'd9, 3'd2, 32'h0000_1111, "R4");
    rd_word(2, "R4");
    cyc(1, 0, 4'd11, 3'd2, 32'h0, "R4");

    // R5 misaligned words refused
    for (int a = 1; a < 4; a++) cyc(1, 1, 4'(4+a), 3'd4, 32'hDEAD_0000 + a, "R5");
    rd_word(1, "R5");
    cyc(1, 0, 4'd2, 3'd4, 32'h0, "R5");

    // R6 unknown size codes
    for (int s = 0; s < 8; s++)
      if (s != 1 && s != 2 && s != 4) cyc(1, 1, 4'd0, 3'(s), 32'hFFFF_FFFF, "R6");
    rd_word(0, "R6");

    // R7 right-aligned reads with upper bits zero
    cyc(1, 1, 4'd0, 3'd4, 32'hF1E2_D3C4, "R7");
    for (int a = 0; a < 4; a++) cyc(1, 0, 4'(a), 3'd1, 32'h0, "R7");
    cyc(1, 0, 4'd0, 3'd2, 32'h0, "R7");
    cyc(1, 0, 4'd2, 3'd2, 32'h0, "R7");

    // R9 read-only register ignores every write size, no error
    cyc(1, 1, 4'd12, 3'd4, 32'h0BAD_F00D, "R9");
    cyc(1, 1, 4'd13, 3'd1, 32'h0000_0077, "R9");
    cyc(1, 1, 4'd14, 3'd2, 32'h0000_5555, "R9");
    rd_word(3, "R9");

    // R10 no strobe: nothing happens
    cyc(0, 1, 4'd0, 3'd4, 32'h0000_0000, "R10");
    cyc(0, 0, 4'd4, 3'd1, 32'h0, "R10");
    rd_word(0, "R10");

    // R11 back-to-back mixed traffic, legal and illegal on the same edge stream
    for (int i = 0; i < 800; i++) begin
      logic [2:0] szs [8] = '{3'd1, 3'd2, 3'd4, 3'd1, 3'd2, 3'd4, 3'd0, 3'd3};
      cyc(($urandom % 8) != 0, $urandom % 2, 4'($urandom % 16),
          szs[$urandom % 8], $urandom, "R11");
    end
    for (int i = 0; i < NREGS; i++) rd_word(i, "R11");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule